// File: doc/BRIEF.md
# DRAM Refresh and Access Timer

This block drives an asynchronous DRAM with a multiplexed address bus and serves a simple host request port. A free-running interval timer raises refresh work at a fixed pace. Each refresh is a row-only cycle: the row strobe is asserted with an internal row pointer on the address bus and the column strobe is never asserted. The row pointer then advances, so all rows are visited in turn within the retention period. With 256 rows and a 4 ms retention window, one refresh is due every 15.625 µs. At 100 MHz that is 1562 clocks.

Host reads and writes use a request/acknowledge handshake. The controller presents the row half of the address while the row strobe falls. It then presents the column half under the column strobe, with write enable or output enable chosen by the transfer direction. Read data is taken from the array at the last cycle of the access phase. Every operation, refresh or host, holds the row strobe low for a fixed access phase and then keeps all strobes high for a recharge phase. Nothing new may begin until the recharge phase has ended.

Refresh work that is waiting takes priority over a host request that has not yet started. A host access already under way always completes. If interval expiries arrive faster than refreshes can be served, they accumulate in a small saturating backlog count rather than being lost.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, all four strobes are high, `host_ack` is low and `refresh_backlog` is 0.
- R2: One refresh request is added every `REFRESH_INTERVAL` clocks, counted from reset release. Over a run, the refreshes served plus the backlog equal the elapsed intervals, within one.
- R3: Refresh cycles present row addresses 0, 1, 2, … in order. The pointer wraps from 2^`ROW_BITS`−1 back to 0.
- R4: In a host cycle, the first cycle with the row strobe low carries the row field `host_addr[ROW_BITS+COL_BITS-1:COL_BITS]`. Every cycle with the column strobe low carries the column field `host_addr[COL_BITS-1:0]`.
- R5: The row strobe stays low for exactly `ACCESS_CYC` clocks per operation. It then stays high for at least `RECHARGE_CYC`+1 clocks: the recharge phase plus one idle decision cycle.
- R6: A refresh cycle never lowers the column strobe. A host cycle lowers it for `ACCESS_CYC`−1 clocks, starting in the second row-strobe cycle. The column strobe is only ever low while the row strobe is low.
- R7: While the column strobe is low, write enable is low for a write (`host_we`=1) and output enable is low for a read (`host_we`=0). The two are never low together.
- R8: A read returns on `host_rdata` the array value sampled in the last access cycle. That value is the data most recently written to the same address.
- R9: A host cycle starts only from an idle cycle in which `refresh_backlog` is 0. An idle cycle with a nonzero backlog always starts a refresh.
- R10: `refresh_backlog` rises by one on each interval expiry and falls by one when a refresh starts. Both events in the same clock leave it unchanged. It saturates at 2^`PEND_W`−1.
- R11: Each request is answered by exactly one single-cycle `host_ack`, in the first recharge cycle of its access, together with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_BITS+COL_BITS | Row field in the upper bits, column field in the lower bits |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with `host_ack` |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_wdata | output | DATA_W | Data driven to the array |
| dram_rdata | input | DATA_W | Data from the array |
| refresh_backlog | output | PEND_W | Refresh requests not yet started |

## Verification
Two events can meet in one idle cycle: an interval expiry and the arrival of a host request. The bench provokes this on purpose by raising a request on the clock just before the timer expires, and random gaps hit the same cycle again. The expected winner is derived from the backlog value seen in that idle cycle. Each row-strobe period is then classified by whether the column strobe appeared, and compared with that winner. On a second instance the interval is shorter than one operation, so an expiry and a refresh start repeatedly land on the same edge. There the backlog is compared every clock against a bench count of expiries and starts, including saturation.

// File: rtl/drc_pkg.sv
package drc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_ACCESS   = 2'd1,
      PH_RECHARGE = 2'd2
   } phase_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/drc_refresh_pacer.sv
module drc_refresh_pacer #(
   parameter int unsigned INTERVAL = 1562,
   parameter int unsigned ROW_BITS = 8,
   parameter int unsigned PEND_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                advance,
   output logic [PEND_W-1:0]   pending,
   output logic [ROW_BITS-1:0] row,
   output logic                want
);
   localparam int unsigned TICK_W = drc_pkg::width_of(INTERVAL);
   localparam logic [PEND_W-1:0] PEND_MAX = '1;

   if (INTERVAL < 2) begin : g_bad_interval
      $error("refresh interval must be at least two clocks");
   end
   if (PEND_W < 1) begin : g_bad_pend
      $error("backlog width must be at least one bit");
   end

   logic [TICK_W-1:0] tick_cnt;
   logic              tick;

   assign tick = (tick_cnt == TICK_W'(INTERVAL - 1));
   assign want = (pending != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
         pending  <= '0;
         row      <= '0;
      end else begin
         tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
         if (tick && !take && (pending != PEND_MAX))
            pending <= pending + 1'b1;
         else if (take && !tick)
            pending <= pending - 1'b1;
         if (advance)
            row <= row + 1'b1;
      end
   end

   // R10: backlog moves by at most one step per clock
   a_r10_backlog_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pending != $past(pending)) |->
         ((pending == $past(pending) + PEND_W'(1)) || (pending == $past(pending) - PEND_W'(1))));

   // R3: row pointer only ever steps forward by one
   a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (row != $past(row)) |-> (row == $past(row) + ROW_BITS'(1)));

endmodule

// File: rtl/drc_phase_seq.sv
module drc_phase_seq #(
   parameter int unsigned ACCESS_CYC   = 6,
   parameter int unsigned RECHARGE_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output drc_pkg::phase_e phase,
   output logic            first_acc,
   output logic            last_acc
);
   import drc_pkg::*;

   localparam int unsigned LONGEST = (ACCESS_CYC > RECHARGE_CYC) ? ACCESS_CYC : RECHARGE_CYC;
   localparam int unsigned CNT_W   = width_of(LONGEST);

   logic [CNT_W-1:0] cnt;
   logic             last_rch;

   assign first_acc = (phase == PH_ACCESS) && (cnt == '0);
   assign last_acc  = (phase == PH_ACCESS) && (cnt == CNT_W'(ACCESS_CYC - 1));
   assign last_rch  = (phase == PH_RECHARGE) && (cnt == CNT_W'(RECHARGE_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_ACCESS;
            end
            PH_ACCESS: begin
               if (last_acc) begin
                  phase <= PH_RECHARGE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_RECHARGE: begin
               if (last_rch) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R5: a start request is only honoured from idle
   a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACCESS && $past(phase) != PH_ACCESS) |-> ($past(phase) == PH_IDLE && $past(start)));

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
   parameter int unsigned ROW_BITS         = 8,
   parameter int unsigned COL_BITS         = 8,
   parameter int unsigned DATA_W           = 4,
   parameter int unsigned REFRESH_INTERVAL = 1562,
   parameter int unsigned ACCESS_CYC       = 6,
   parameter int unsigned RECHARGE_CYC     = 4,
   parameter int unsigned PEND_W           = 3,
   localparam int unsigned ADDR_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
   localparam int unsigned HADDR_W = ROW_BITS + COL_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic               host_ack,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [ADDR_W-1:0]  dram_addr,
   output logic               dram_ras_n,
   output logic               dram_cas_n,
   output logic               dram_we_n,
   output logic               dram_oe_n,
   output logic [DATA_W-1:0]  dram_wdata,
   input  logic [DATA_W-1:0]  dram_rdata,
   output logic [PEND_W-1:0]  refresh_backlog
);
   import drc_pkg::*;

   localparam int unsigned LO_W = width_of(ACCESS_CYC + 2);
   localparam int unsigned HI_W = width_of(RECHARGE_CYC + 2);

   if (ACCESS_CYC < 2) begin : g_bad_access
      $error("access phase needs a row cycle and at least one column cycle");
   end
   if (RECHARGE_CYC < 1) begin : g_bad_recharge
      $error("recharge phase must be at least one clock");
   end

   phase_e              phase;
   logic                first_acc, last_acc;
   logic                want, pick_ref, pick_host, start, advance;
   logic [ROW_BITS-1:0] ref_row;
   logic                op_ref, op_we;
   logic [ROW_BITS-1:0] op_row;
   logic [COL_BITS-1:0] op_col;
   logic [ADDR_W-1:0]   row_word, col_word;
   logic                in_acc, col_phase;

   // arbitration: refresh backlog wins every idle decision
   assign pick_ref  = (phase == PH_IDLE) && want;
   assign pick_host = (phase == PH_IDLE) && !want && host_req;
   assign start     = pick_ref || pick_host;
   assign advance   = last_acc && op_ref;

   drc_refresh_pacer #(
      .INTERVAL (REFRESH_INTERVAL),
      .ROW_BITS (ROW_BITS),
      .PEND_W   (PEND_W)
   ) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (pick_ref),
      .advance (advance),
      .pending (refresh_backlog),
      .row     (ref_row),
      .want    (want)
   );

   drc_phase_seq #(
      .ACCESS_CYC   (ACCESS_CYC),
      .RECHARGE_CYC (RECHARGE_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .phase     (phase),
      .first_acc (first_acc),
      .last_acc  (last_acc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_ref     <= 1'b0;
         op_we      <= 1'b0;
         op_row     <= '0;
         op_col     <= '0;
         dram_wdata <= '0;
         host_ack   <= 1'b0;
         host_rdata <= '0;
      end else begin
         if (pick_ref) begin
            op_ref <= 1'b1;
            op_we  <= 1'b0;
            op_row <= ref_row;
         end else if (pick_host) begin
            op_ref     <= 1'b0;
            op_we      <= host_we;
            op_row     <= host_addr[HADDR_W-1:COL_BITS];
            op_col     <= host_addr[COL_BITS-1:0];
            dram_wdata <= host_wdata;
         end
         host_ack <= last_acc && !op_ref;
         if (last_acc && !op_ref)
            host_rdata <= dram_rdata;
      end
   end

   // address multiplexer: pad the narrower field to the bus width
   if (ROW_BITS == ADDR_W) begin : g_row_full
      assign row_word = op_row;
   end else begin : g_row_pad
      assign row_word = {{(ADDR_W - ROW_BITS){1'b0}}, op_row};
   end
   if (COL_BITS == ADDR_W) begin : g_col_full
      assign col_word = op_col;
   end else begin : g_col_pad
      assign col_word = {{(ADDR_W - COL_BITS){1'b0}}, op_col};
   end

   assign in_acc     = (phase == PH_ACCESS);
   assign col_phase  = in_acc && !first_acc && !op_ref;
   assign dram_ras_n = !in_acc;
   assign dram_cas_n = !col_phase;
   assign dram_we_n  = !(col_phase && op_we);
   assign dram_oe_n  = !(col_phase && !op_we);
   assign dram_addr  = col_phase ? col_word : row_word;

   // independent strobe-width counters for the timing checks
   logic [LO_W-1:0] lo_cnt;
   logic [HI_W-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= HI_W'(RECHARGE_CYC);
      end else begin
         lo_cnt <= dram_ras_n ? '0 : lo_cnt + 1'b1;
         if (!dram_ras_n)
            hi_cnt <= '0;
         else if (hi_cnt != HI_W'(RECHARGE_CYC))
            hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R5: row strobe low for exactly the access phase
   a_r5_access_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (lo_cnt == LO_W'(ACCESS_CYC)));

   // R5: recharge respected before the next row strobe
   a_r5_recharge_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt == HI_W'(RECHARGE_CYC)));

   // R6: column strobe only inside a row strobe period
   a_r6_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   // R7: write and output enables are exclusive and need the column strobe
   a_r7_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_we_n || !dram_oe_n) |-> (!dram_cas_n && (dram_we_n != dram_oe_n)));

   // R11: acknowledge is a single-clock pulse
   a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   // R11: acknowledge lands at the start of the recharge phase
   a_r11_ack_at_recharge: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |-> (phase == PH_RECHARGE && $past(!dram_cas_n)));

endmodule

// File: tb/test_dram_cycle_ctrl.sv
module test_dram_cycle_ctrl;

   localparam int ROWB = 8;
   localparam int COLB = 4;
   localparam int DW   = 4;
   localparam int IVL  = 60;
   localparam int ACC  = 6;
   localparam int RCH  = 4;
   localparam int IVL_B = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- instance A: host traffic ----------------
   logic                 host_req = 1'b0, host_we = 1'b0;
   logic [ROWB+COLB-1:0] host_addr = '0;
   logic [DW-1:0]        host_wdata = '0;
   logic                 host_ack;
   logic [DW-1:0]        host_rdata;
   logic [ROWB-1:0]      a_addr;
   logic                 a_ras_n, a_cas_n, a_we_n, a_oe_n;
   logic [DW-1:0]        a_wdata, a_rdata;
   logic [2:0]           a_backlog;

   dram_cycle_ctrl #(
      .ROW_BITS(ROWB), .COL_BITS(COLB), .DATA_W(DW),
      .REFRESH_INTERVAL(IVL), .ACCESS_CYC(ACC), .RECHARGE_CYC(RCH), .PEND_W(3)
   ) i_dram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_ack(host_ack), .host_rdata(host_rdata),
      .dram_addr(a_addr), .dram_ras_n(a_ras_n), .dram_cas_n(a_cas_n),
      .dram_we_n(a_we_n), .dram_oe_n(a_oe_n), .dram_wdata(a_wdata), .dram_rdata(a_rdata),
      .refresh_backlog(a_backlog)
   );

   // ---------------- instance B: backlog saturation ----------------
   logic [ROWB-1:0] b_addr;
   logic            b_ras_n, b_cas_n, b_we_n, b_oe_n, b_ack;
   logic [DW-1:0]   b_wdata, b_rdata_out;
   logic [1:0]      b_backlog;

   dram_cycle_ctrl #(
      .ROW_BITS(ROWB), .COL_BITS(COLB), .DATA_W(DW),
      .REFRESH_INTERVAL(IVL_B), .ACCESS_CYC(ACC), .RECHARGE_CYC(RCH), .PEND_W(2)
   ) i_dram_cycle_ctrl_sat (
      .clk(clk), .rst_n(rst_n),
      .host_req(1'b0), .host_we(1'b0), .host_addr('0), .host_wdata('0),
      .host_ack(b_ack), .host_rdata(b_rdata_out),
      .dram_addr(b_addr), .dram_ras_n(b_ras_n), .dram_cas_n(b_cas_n),
      .dram_we_n(b_we_n), .dram_oe_n(b_oe_n), .dram_wdata(b_wdata), .dram_rdata('0),
      .refresh_backlog(b_backlog)
   );

   // clocks since reset release
   int n = 0;
   always @(posedge clk) if (!rst_n) n <= 0; else n <= n + 1;

   // ---------------- array model and strobe monitor for A ----------------
   logic [DW-1:0] mem    [256];
   logic [DW-1:0] shadow [256];
   logic [ROWB-1:0] lat_row = '0;
   logic [ROWB-1:0] cur_row = '0;
   logic [COLB-1:0] cur_col = '0;
   bit   cur_we = 1'b0;

   assign a_rdata = (!a_oe_n) ? mem[{lat_row[3:0], a_addr[3:0]}] : '0;

   bit   mon_on = 1'b0;
   bit   ras_prev = 1'b1;
   int   lo_len = 0, hi_len = 1000, cas_len = 0;
   bit   had_cas = 1'b0, began_with_backlog = 1'b0;
   int   prev_backlog = 0;
   int   exp_ref_row = 0;
   int   ref_cnt = 0;
   int   wraps = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         if (ras_prev && !a_ras_n) begin
            chk(hi_len >= RCH + 1, "R5 recharge", hi_len, RCH + 1);
            lat_row = a_addr;
            lo_len = 1; cas_len = 0; had_cas = 1'b0;
            began_with_backlog = (prev_backlog != 0);
         end else if (!a_ras_n) begin
            lo_len++;
         end
         if (!a_cas_n) begin
            had_cas = 1'b1;
            cas_len++;
            chk(a_addr[3:0] == cur_col, "R4 column", int'(a_addr[3:0]), int'(cur_col));
            chk(a_we_n == !cur_we && a_oe_n == cur_we, "R7 enables",
                int'({a_we_n, a_oe_n}), int'({!cur_we, cur_we}));
            if (!a_we_n) mem[{lat_row[3:0], a_addr[3:0]}] = a_wdata;
         end else begin
            chk(a_we_n && a_oe_n, "R7 idle enables", int'({a_we_n, a_oe_n}), 3);
         end
         if (!ras_prev && a_ras_n) begin
            chk(lo_len == ACC, "R5 access", lo_len, ACC);
            chk(had_cas == !began_with_backlog, "R9 arbitration", int'(had_cas), int'(!began_with_backlog));
            if (!had_cas) begin
               chk(int'(lat_row) == exp_ref_row, "R3 row order", int'(lat_row), exp_ref_row);
               if (exp_ref_row == 255) wraps++;
               exp_ref_row = (exp_ref_row + 1) % 256;
               ref_cnt++;
            end else begin
               chk(cas_len == ACC - 1, "R6 cas length", cas_len, ACC - 1);
               chk(lat_row == cur_row, "R4 row", int'(lat_row), int'(cur_row));
            end
            hi_len = 1;
         end else if (a_ras_n) begin
            hi_len++;
         end
         ras_prev = a_ras_n;
         prev_backlog = int'(a_backlog);
      end
   end

   // ---------------- backlog model for B ----------------
   bit b_on = 1'b0;
   bit b_ras_prev = 1'b1;
   int b_exp = 0;
   always @(negedge clk) begin
      if (b_on) begin
         bit tick, take;
         tick = (n != 0) && (n % IVL_B == 0);
         take = b_ras_prev && !b_ras_n;
         if (tick && !take && b_exp != 3) b_exp++;
         else if (take && !tick) b_exp--;
         chk(int'(b_backlog) == b_exp, "R10 backlog", int'(b_backlog), b_exp);
         chk(b_cas_n, "R6 refresh without cas", int'(b_cas_n), 1);
         b_ras_prev = b_ras_n;
      end
   end

   // ---------------- host task ----------------
   task automatic host_op(input bit we, input logic [ROWB-1:0] row,
                          input logic [COLB-1:0] col, input logic [DW-1:0] d);
      @(negedge clk);
      cur_row = row; cur_col = col; cur_we = we;
      host_addr = {row, col}; host_we = we; host_wdata = d; host_req = 1'b1;
      do @(negedge clk); while (!host_ack);
      host_req = 1'b0;
      if (we) shadow[{row[3:0], col}] = d;
      else chk(host_rdata == shadow[{row[3:0], col}], "R8 read data",
               int'(host_rdata), int'(shadow[{row[3:0], col}]));
      @(negedge clk);
      chk(!host_ack, "R11 single ack", int'(host_ack), 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   // ---------------- main stimulus ----------------
   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(20240);
      for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
      repeat (4) @(negedge clk);
      chk(a_ras_n && a_cas_n && a_we_n && a_oe_n, "R1 strobes",
          int'({a_ras_n, a_cas_n, a_we_n, a_oe_n}), 15);
      chk(!host_ack, "R1 ack", int'(host_ack), 0);
      chk(a_backlog == 0, "R1 backlog", int'(a_backlog), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      b_on = 1'b1;

      // directed: write then read the corner addresses
      host_op(1'b1, 8'd0,  4'd0,  4'hA);
      host_op(1'b1, 8'd15, 4'd15, 4'h5);
      host_op(1'b0, 8'd0,  4'd0,  4'h0);
      host_op(1'b0, 8'd15, 4'd15, 4'h0);

      // directed: request lands in the cycle the interval expires
      for (int k = 0; k < 4; k++) begin
         while ((n % IVL) != IVL - 2) @(negedge clk);
         host_op(1'(k & 1), 8'(k), 4'(k + 3), 4'(k + 9));
      end

      b_on = 1'b0;

      // random traffic
      for (int k = 0; k < 700; k++) begin
         int gap;
         host_op(1'($urandom_range(0, 1)), 8'($urandom_range(0, 15)),
                 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
         gap = $urandom_range(0, 20);
         repeat (gap) @(negedge clk);
      end

      while (ref_cnt < 260) @(negedge clk);
      chk(wraps >= 1, "R3 wrap", wraps, 1);
      begin
         int diff;
         diff = (n / IVL) - ref_cnt - int'(a_backlog);
         chk(diff >= -1 && diff <= 1, "R2 refresh pace", diff, 0);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule